// File: doc/BRIEF.md
# Digit-Serial Redundant-Basis Binary Field Multiplier

This block multiplies two binary field elements held in redundant-basis form. Each operand is an N-bit vector of coefficients over the powers 1, β, …, β^(N−1) of a primitive N-th root of unity β. Bit i of an operand is the coefficient of β^i. In this basis the product is the cyclic convolution of the two coefficient vectors modulo x^N − 1. No modular reduction step exists beyond a circular index wrap, so squaring and reduction cost nothing in hardware.

Operand B is captured whole. Operand A is consumed as S = ceil(N/D) digits of D bits each, least-significant digit first. A row of D partial-product units each ANDs one A bit with a circularly rotated copy of B and XORs the result into a partial sum that moves down the row. A register sits between units, so each cycle costs one AND and one XOR. The A bits and the rotated B copies are delayed so that each unit sees them in step with the partial sum. A single accumulator folds each digit's partial product into the running result as soon as it leaves the row. A new operand pair can start every S cycles.

The host pulses `start_i` with the operands on the same clock edge. It reads `prod_o` in the single cycle in which `done_o` is high.

Top module: `rb_digit_mult`

## Requirements
- R1: A clock edge with `rst` high leaves `done_o` at 0 and `prod_o` at all zeros in the following cycle. An operation in flight when reset is applied never produces a `done_o` pulse.
- R2: The product satisfies `prod_o[j]` = XOR over i in 0..N−1 of (`a_i[i]` AND `b_i[(j − i) mod N]`). Digit k covers A bits kD … kD+D−1, and A bits at positions N and above are treated as zero. The wrap stays modulo N even when N is not a multiple of D.
- R3: A start accepted at clock edge E gives `done_o` high, with the product, in the cycle that follows edge E + S + D.
- R4: `done_o` is a single-cycle pulse, and there is exactly one pulse per accepted start.
- R5: A start is accepted when no operation is in progress, or at the S-th edge after the previous accepted start. Starts on every S-th edge therefore yield one correct product every S cycles.
- R6: A start at any of the S−1 edges that follow an accepted start is ignored. It adds no `done_o` pulse and does not change the product of the operation in progress.
- R7: The operands are sampled only at the edge of an accepted start. Later changes on `a_i` and `b_i` do not affect that product.
- R8: Corner operands give their field results. A zero operand yields zero. All-ones times all-ones yields N mod 2 in every bit. A single set bit at position p in one operand yields the other operand rotated left by p positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication with the operands present at this edge |
| a_i | input | N | Operand A, consumed as D-bit digits |
| b_i | input | N | Operand B, captured whole |
| prod_o | output | N | Registered product; meaningful while `done_o` is high |
| done_o | output | 1 | One-cycle pulse marking a valid product |

## Verification
The checker assumes that reset is synchronous and held for at least one edge. It also assumes that the first start after reset finds the block idle, which is why it can bound the first result's latency from the first `start_i` it sees. `start_i` is otherwise unconstrained, since the block itself decides which starts to take. The stimulus therefore fires extra starts inside an operation, starts exactly on the S-cycle boundary, and changes the operands right after each start. It also applies reset in the middle of an operation, and it always drives inputs one time unit after the rising edge so they are stable at every sampling edge.

// File: rtl/rb_mult_pkg.sv
package rb_mult_pkg;

  // Number of D-bit digits needed to cover N operand bits.
  function automatic int digit_count(input int n, input int d);
    return (n + d - 1) / d;
  endfunction

  // Counter width able to hold 0..v-1, never below one bit.
  function automatic int count_width(input int v);
    return (v <= 2) ? 1 : $clog2(v);
  endfunction

  // Source index for bit j of a vector rotated left by k positions, modulo n.
  function automatic int rot_src(input int j, input int k, input int n);
    return ((j - (k % n)) % n + n) % n;
  endfunction

endpackage

// File: rtl/rb_delay.sv
module rb_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) sr[k] <= '0;
    end else begin
      sr[0] <= din;
      for (int k = 1; k < DEPTH; k++) sr[k] <= sr[k-1];
    end
  end

  assign dout = sr[DEPTH-1];

endmodule

// File: rtl/rb_digit_feed.sv
module rb_digit_feed
  import rb_mult_pkg::*;
#(
  parameter int N = 11,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         vld_o,
  output logic         first_o,
  output logic         last_o,
  output logic [D-1:0] dig_o,
  output logic [N-1:0] b_o
);

  localparam int S  = digit_count(N, D);
  localparam int SD = S * D;
  localparam int CW = count_width(S);
  localparam logic [CW-1:0] LAST_IDX = CW'(S - 1);

  logic          busy;
  logic [CW-1:0] dcnt;
  logic [SD-1:0] a_sh;
  logic [N-1:0]  b_rot;
  logic [N-1:0]  b_nxt;
  logic          accept;
  logic          take;

  // Advancing to the next digit's B group is a fixed rotation by D: wiring only.
  for (genvar j = 0; j < N; j++) begin : g_rot
    assign b_nxt[j] = b_rot[rot_src(j, D, N)];
  end

  assign accept = !busy || (dcnt == LAST_IDX);
  assign take   = start_i && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      dcnt  <= '0;
      a_sh  <= '0;
      b_rot <= '0;
    end else if (take) begin
      busy  <= 1'b1;
      dcnt  <= '0;
      a_sh  <= SD'(a_i);
      b_rot <= b_i;
    end else if (busy) begin
      a_sh  <= a_sh >> D;
      b_rot <= b_nxt;
      dcnt  <= dcnt + 1'b1;
      if (dcnt == LAST_IDX) busy <= 1'b0;
    end
  end

  assign vld_o   = busy;
  assign first_o = busy && (dcnt == '0);
  assign last_o  = busy && (dcnt == LAST_IDX);
  assign dig_o   = a_sh[D-1:0];
  assign b_o     = b_rot;

endmodule

// File: rtl/rb_pp_unit.sv
module rb_pp_unit
  import rb_mult_pkg::*;
#(
  parameter int N = 11,
  parameter int T = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abit_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] sum_i,
  output logic [N-1:0] sum_o
);

  logic [N-1:0] term;

  // Rotation of the digit's B group by T is wiring; one AND per bit.
  for (genvar j = 0; j < N; j++) begin : g_and
    assign term[j] = abit_i & b_i[rot_src(j, T, N)];
  end

  always_ff @(posedge clk) begin
    if (rst) sum_o <= '0;
    else     sum_o <= sum_i ^ term;
  end

endmodule

// File: rtl/rb_accum.sv
module rb_accum #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic [N-1:0] pp_i,
  output logic [N-1:0] prod_o,
  output logic         done_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= vld_i && last_i;
      if (vld_i) prod_o <= first_i ? pp_i : (prod_o ^ pp_i);
    end
  end

endmodule

// File: rtl/rb_digit_mult.sv
module rb_digit_mult #(
  parameter int N = 11,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N-1:0] prod_o,
  output logic         done_o
);

  logic         f_vld, f_first, f_last;
  logic [D-1:0] f_dig;
  logic [N-1:0] f_b;

  logic [D-1:0][N-1:0] b_stg;
  logic [D-1:0][N-1:0] sum_stg;
  logic [D-1:0]        abit_stg;
  logic [2:0]          flg;

  rb_digit_feed #(.N(N), .D(D)) u_feed (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .vld_o   (f_vld),
    .first_o (f_first),
    .last_o  (f_last),
    .dig_o   (f_dig),
    .b_o     (f_b)
  );

  for (genvar t = 0; t < D; t++) begin : g_row
    if (t == 0) begin : g_head
      assign b_stg[0]    = f_b;
      assign abit_stg[0] = f_dig[0];
      rb_pp_unit #(.N(N), .T(0)) u_pp (
        .clk    (clk),
        .rst    (rst),
        .abit_i (abit_stg[0]),
        .b_i    (b_stg[0]),
        .sum_i  ({N{1'b0}}),
        .sum_o  (sum_stg[0])
      );
    end else begin : g_body
      // Cut-set register on the B copy between neighbouring units.
      rb_delay #(.W(N), .DEPTH(1)) u_bdly (
        .clk  (clk),
        .rst  (rst),
        .din  (b_stg[t-1]),
        .dout (b_stg[t])
      );
      // Digit bit t enters t cycles late to meet the partial sum.
      rb_delay #(.W(1), .DEPTH(t)) u_adly (
        .clk  (clk),
        .rst  (rst),
        .din  (f_dig[t]),
        .dout (abit_stg[t])
      );
      rb_pp_unit #(.N(N), .T(t)) u_pp (
        .clk    (clk),
        .rst    (rst),
        .abit_i (abit_stg[t]),
        .b_i    (b_stg[t]),
        .sum_i  (sum_stg[t-1]),
        .sum_o  (sum_stg[t])
      );
    end
  end

  rb_delay #(.W(3), .DEPTH(D)) u_fdly (
    .clk  (clk),
    .rst  (rst),
    .din  ({f_vld, f_first, f_last}),
    .dout (flg)
  );

  rb_accum #(.N(N)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .vld_i   (flg[2]),
    .first_i (flg[1]),
    .last_i  (flg[0]),
    .pp_i    (sum_stg[D-1]),
    .prod_o  (prod_o),
    .done_o  (done_o)
  );

endmodule

// File: rtl/rb_digit_mult_chk.sv
module rb_digit_mult_chk
  import rb_mult_pkg::*;
#(
  parameter int N = 11,
  parameter int D = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         start_i,
  input logic [N-1:0] prod_o,
  input logic         done_o
);

  localparam int S   = digit_count(N, D);
  localparam int LAT = S + D;

  int  gap;
  bit  seen_done;
  int  since;
  bit  started;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= 0;
      seen_done <= 1'b0;
    end else if (done_o) begin
      gap       <= 0;
      seen_done <= 1'b1;
    end else if (gap < S) begin
      gap <= gap + 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b0;
      since   <= 0;
    end else if (start_i && !started) begin
      started <= 1'b1;
      since   <= 0;
    end else if (started && since < LAT) begin
      since <= since + 1;
    end
  end

  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (!done_o && prod_o == '0)); // R1

  AST_FIRST_LATENCY: assert property (@(posedge clk) disable iff (rst) done_o |-> (started && since >= LAT)); // R3

  AST_DONE_SPACING: assert property (@(posedge clk) disable iff (rst) (done_o && seen_done) |-> (gap >= S - 1)); // R5

  if (S > 1) begin : g_pulse
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R4
  end

endmodule

bind rb_digit_mult rb_digit_mult_chk #(.N(N), .D(D)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .prod_o  (prod_o),
  .done_o  (done_o)
);

// File: tb/rb_digit_mult_bench.sv
module rb_digit_mult_bench;

  localparam int N   = 11;
  localparam int D   = 3;
  localparam int S   = (N + D - 1) / D;
  localparam int LAT = S + D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [N-1:0] a_i = '0;
  logic [N-1:0] b_i = '0;
  logic [N-1:0] prod_o;
  logic         done_o;

  always #2 clk = ~clk;

  rb_digit_mult #(.N(N), .D(D)) u_rb_digit_mult (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .prod_o  (prod_o),
    .done_o  (done_o)
  );

  typedef struct {
    int           due;
    logic [N-1:0] val;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    last_acc = -1000;
  bit    chk_on = 1'b0;
  string tag = "R2";

  function automatic logic [N-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [N-1:0] c;
    c = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        c[j] = c[j] ^ (a[i] & b[(j - i + N) % N]);
    return c;
  endfunction

  function automatic logic [N-1:0] rnd_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom);
    return v;
  endfunction

  // Behavioural model: acceptance rule (R5, R6) and latency (R3) from the requirements.
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      q.delete();
      last_acc = -1000;
    end else if (start_i && (cyc - last_acc >= S)) begin
      q.push_back('{cyc + LAT, ref_mul(a_i, b_i)});
      last_acc = cyc;
    end
  end

  always @(negedge clk) begin : cmp
    logic exp_d;
    if (chk_on && !rst) begin
      exp_d = (q.size() > 0) && (q[0].due == cyc);
      n_chk++;
      if (done_o !== exp_d) begin
        n_fail++;
        $display("FAIL %s R3 R4 cycle %0d done_o=%0b expected %0b", tag, cyc, done_o, exp_d);
      end
      if (exp_d) begin
        n_chk++;
        if (prod_o !== q[0].val) begin
          n_fail++;
          $display("FAIL %s R2 cycle %0d prod_o=%h expected %h", tag, cyc, prod_o, q[0].val);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk_r1();
    n_chk++;
    if (done_o !== 1'b0 || prod_o !== '0) begin
      n_fail++;
      $display("FAIL R1 done_o=%0b prod_o=%h expected 0 and %h", done_o, prod_o, {N{1'b0}});
    end
  endtask

  // Operands change right after the start edge (R7).
  task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b);
    start_i = 1'b1;
    a_i     = a;
    b_i     = b;
    tick(1);
    start_i = 1'b0;
    a_i     = rnd_vec();
    b_i     = rnd_vec();
  endtask

  task automatic run_one(input logic [N-1:0] a, input logic [N-1:0] b);
    issue(a, b);
    tick(LAT + 2);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    summary();
    $finish;
  end

  initial begin
    logic [N-1:0] e;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_r1();
    @(posedge clk);
    #1;
    rst    = 1'b0;
    chk_on = 1'b1;
    tick(2);

    // R8: corner operands
    tag = "R8";
    run_one('0, rnd_vec());
    run_one(rnd_vec(), '0);
    run_one('1, '1);
    for (int p = 0; p < N; p++) begin
      e = '0;
      e[p] = 1'b1;
      run_one(e, rnd_vec());
      run_one(rnd_vec(), e);
    end

    // R2: random operands, isolated operations
    tag = "R2";
    for (int k = 0; k < 20; k++) run_one(rnd_vec(), rnd_vec());

    // R7: operands scrambled right after the start edge
    tag = "R7";
    for (int k = 0; k < 4; k++) run_one(rnd_vec(), rnd_vec());

    // R5: back-to-back at one pair per S cycles
    tag = "R5";
    for (int k = 0; k < 10; k++) begin
      issue(rnd_vec(), rnd_vec());
      tick(S - 1);
    end
    tick(LAT + 2);

    // R6: starts inside an operation are ignored
    tag = "R6";
    for (int r = 0; r < 3; r++) begin
      issue(rnd_vec(), rnd_vec());
      for (int k = 1; k < S; k++) begin
        start_i = 1'b1;
        a_i     = rnd_vec();
        b_i     = rnd_vec();
        tick(1);
      end
      start_i = 1'b0;
      tick(LAT + 2);
    end

    // R1: reset in the middle of an operation
    tag = "R1";
    issue(rnd_vec(), rnd_vec());
    tick(2);
    rst = 1'b1;
    tick(1);
    @(negedge clk);
    chk_r1();
    @(posedge clk);
    #1;
    rst = 1'b0;
    tick(LAT + 4);

    tag = "R2";
    run_one(rnd_vec(), rnd_vec());

    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R4 pending results=%0d expected 0", q.size());
    end
    summary();
    $finish;
  end

endmodule